// File: doc/BRIEF.md
# Low-Power-Idle Transmit Sequencer

This block is the transmit-side low power idle controller of a 100G PCS. It watches an LPI request from the reconciliation layer and walks the transmit path through its power states. Those states are active data, sleep, quiet, alert and wake, plus a fast-wake hold. The current state goes out as a 3-bit `tx_mode` code toward the PMA/PMD. Every dwell time comes from a timer counted in clock cycles. The cycle counts are derived at elaboration from nanosecond parameters and the clock period in picoseconds.

States: DATA (traffic), SLEEP (LPI blocks sent before going silent), QUIET (transmitter off), ALERT (alert signal ahead of a wake), WAKE (link restart; rapid alignment markers start here) and FW (fast-wake hold, where the lower layer sends its own pattern instead of going silent). Transitions:

- DATA→SLEEP or DATA→FW on request, chosen by the fast-wake enable.
- SLEEP→QUIET on sleep expiry, or SLEEP→WAKE on request drop.
- QUIET→ALERT on quiet expiry or request drop.
- ALERT→WAKE on alert expiry.
- WAKE→DATA, WAKE→SLEEP or WAKE→FW on wake expiry.
- FW→WAKE on request drop after the fast sleep time.

`lpi_blk` tells the encoder to emit LPI blocks. `ram_start` is a one-cycle pulse that starts rapid marker insertion.

Top module: `lpi_tx_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, tx_mode reads DATA, lpi_blk is 0 and ram_start is 0. Codes: DATA=0, SLEEP=1, QUIET=2, ALERT=3, WAKE=4, FW=5.
- R2: A request seen in DATA with fast-wake off gives SLEEP in the next cycle. SLEEP lasts exactly the sleep count while the request stays, then becomes QUIET.
- R3: QUIET with the request held lasts the quiet count, then gives ALERT. ALERT lasts the alert count, then gives WAKE. WAKE lasts the normal wake count, then returns to SLEEP (refresh).
- R4: Dropping the request in any cycle of SLEEP, including the cycle its timer expires, gives WAKE next. WAKE then lasts the normal wake count and is followed by DATA.
- R5: Dropping the request in any cycle of QUIET, including the expiry cycle, gives ALERT next. The full alert count follows, then WAKE, then DATA.
- R6: Request changes during ALERT do not change its length or successor.
- R7: A request seen in DATA with fast-wake on gives FW. FW holds with no time limit while the request stays, and never passes through SLEEP or QUIET.
- R8: A drop in FW gives WAKE once FW has lasted at least the fast sleep count. That WAKE lasts the fast wake count, then gives DATA.
- R9: ram_start is 1 for exactly the first cycle of every WAKE and 0 in all other cycles.
- R10: lpi_blk is 1 exactly in SLEEP and FW.
- R11: At wake expiry a present request gives FW if fast-wake is on, or SLEEP if it is off. With no request present, wake expiry gives DATA.
- R12: Each count is ceil(ns*1000/CLK_PS), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpi_req | input | 1 | LPI request from the reconciliation layer |
| fw_en | input | 1 | Fast-wake enable |
| tx_mode | output | 3 | Current transmit mode code |
| lpi_blk | output | 1 | Send LPI blocks |
| ram_start | output | 1 | One-cycle start of rapid marker insertion |

## Verification
A timer expiry and a change of the request can land in the same cycle. The bench provokes this by dropping the request in the last cycle of SLEEP and of QUIET. It also raises the request in the final WAKE cycle. The drop must win in SLEEP and lead to WAKE. In QUIET both events lead to ALERT. At wake expiry the freshly raised request must send the controller back to an LPI state rather than to DATA. Every cycle of each segment is compared against lengths worked out from the nanosecond parameters.

// File: rtl/lpi_tx_pkg.sv
package lpi_tx_pkg;

    typedef enum logic [2:0] {
        M_DATA  = 3'd0,
        M_SLEEP = 3'd1,
        M_QUIET = 3'd2,
        M_ALERT = 3'd3,
        M_WAKE  = 3'd4,
        M_FW    = 3'd5
    } lpi_mode_e;

    // Round a nanosecond duration up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
        longint unsigned c;
        c = (longint'(ns) * 1000 + longint'(clk_ps) - 1) / longint'(clk_ps);
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpi_tmr.sv
module lpi_tmr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Down-counter: loaded on state entry, holds at zero once expired.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lpi_dur_sel.sv
module lpi_dur_sel
    import lpi_tx_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned SL_C   = 1,
    parameter int unsigned FSL_C  = 1,
    parameter int unsigned QT_C   = 1,
    parameter int unsigned AL_C   = 1,
    parameter int unsigned WK_C   = 1,
    parameter int unsigned FWK_C  = 1
) (
    input  lpi_mode_e    nxt,
    input  lpi_mode_e    cur,
    output logic [W-1:0] val
);
    // Value loaded is dwell length minus one, so a state lasts exactly its count.
    always_comb begin
        unique case (nxt)
            M_SLEEP: val = W'(SL_C - 1);
            M_QUIET: val = W'(QT_C - 1);
            M_ALERT: val = W'(AL_C - 1);
            M_WAKE:  val = (cur == M_FW) ? W'(FWK_C - 1) : W'(WK_C - 1);
            M_FW:    val = W'(FSL_C - 1);
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/lpi_tx_ctrl.sv
module lpi_tx_ctrl
    import lpi_tx_pkg::*;
#(
    parameter int unsigned CLK_PS      = 3103,
    parameter int unsigned SLEEP_NS    = 1000,
    parameter int unsigned FW_SLEEP_NS = 250,
    parameter int unsigned QUIET_NS    = 1800000,
    parameter int unsigned ALERT_NS    = 200,
    parameter int unsigned WAKE_NS     = 4000,
    parameter int unsigned FW_WAKE_NS  = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lpi_req,
    input  logic       fw_en,
    output logic [2:0] tx_mode,
    output logic       lpi_blk,
    output logic       ram_start
);
    localparam int unsigned SL_C  = ns_to_cyc(SLEEP_NS,    CLK_PS);
    localparam int unsigned FSL_C = ns_to_cyc(FW_SLEEP_NS, CLK_PS);
    localparam int unsigned QT_C  = ns_to_cyc(QUIET_NS,    CLK_PS);
    localparam int unsigned AL_C  = ns_to_cyc(ALERT_NS,    CLK_PS);
    localparam int unsigned WK_C  = ns_to_cyc(WAKE_NS,     CLK_PS);
    localparam int unsigned FWK_C = ns_to_cyc(FW_WAKE_NS,  CLK_PS);
    localparam int unsigned MAXC  = umax(umax(umax(SL_C, FSL_C), umax(QT_C, AL_C)), umax(WK_C, FWK_C));
    localparam int unsigned TW    = (MAXC < 2) ? 1 : $clog2(MAXC);

    lpi_mode_e     state;
    lpi_mode_e     nxt;
    logic          t_done;
    logic          t_load;
    logic [TW-1:0] t_val;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= M_DATA;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            M_DATA: begin
                if (lpi_req) nxt = fw_en ? M_FW : M_SLEEP;
            end
            M_SLEEP: begin
                if (!lpi_req)    nxt = M_WAKE;
                else if (t_done) nxt = M_QUIET;
            end
            M_QUIET: begin
                if (!lpi_req || t_done) nxt = M_ALERT;
            end
            M_ALERT: begin
                if (t_done) nxt = M_WAKE;
            end
            M_WAKE: begin
                if (t_done) begin
                    if (!lpi_req)  nxt = M_DATA;
                    else if (fw_en) nxt = M_FW;
                    else           nxt = M_SLEEP;
                end
            end
            M_FW: begin
                if (!lpi_req && t_done) nxt = M_WAKE;
            end
            default: nxt = M_DATA;
        endcase
    end

    assign t_load = (nxt != state);

    lpi_dur_sel #(
        .W(TW), .SL_C(SL_C), .FSL_C(FSL_C), .QT_C(QT_C),
        .AL_C(AL_C), .WK_C(WK_C), .FWK_C(FWK_C)
    ) dur_i (
        .nxt (nxt),
        .cur (state),
        .val (t_val)
    );

    lpi_tmr #(.W(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // Output decode
    always_comb begin
        tx_mode = state;
        unique case (state)
            M_SLEEP, M_FW: lpi_blk = 1'b1;
            default:       lpi_blk = 1'b0;
        endcase
    end

    // Marker start pulse, aligned with the first WAKE cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_start <= 1'b0;
        end else begin
            ram_start <= (nxt == M_WAKE) && (state != M_WAKE);
        end
    end
endmodule

// File: rtl/lpi_tx_chk.sv
module lpi_tx_chk
    import lpi_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] tx_mode,
    input logic       ram_start
);
    // R9
    ram_in_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_start |-> (tx_mode == M_WAKE));

    // R9
    ram_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_start |=> !ram_start);

    // R9
    wake_entry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == M_WAKE && $past(tx_mode) != M_WAKE) |-> ram_start);

    // R5
    quiet_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == M_QUIET) |=> (tx_mode == M_QUIET || tx_mode == M_ALERT));

    // R6
    alert_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == M_ALERT) |=> (tx_mode == M_ALERT || tx_mode == M_WAKE));

    // R7
    fw_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == M_FW) |=> (tx_mode == M_FW || tx_mode == M_WAKE));

    // R2
    data_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == M_DATA) |=> (tx_mode == M_DATA || tx_mode == M_SLEEP || tx_mode == M_FW));
endmodule

bind lpi_tx_ctrl lpi_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_mode   (tx_mode),
    .ram_start (ram_start)
);

// File: tb/lpi_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpi_tx_ctrl_tb_top;
    localparam int CLK_NS   = 10;
    localparam int CLK_PS   = CLK_NS * 1000;
    localparam int SL_NS    = 100;
    localparam int FSL_NS   = 30;
    localparam int QT_NS    = 500;
    localparam int AL_NS    = 50;
    localparam int WK_NS    = 200;
    localparam int FWK_NS   = 40;
    // R12: expected counts, rounded up
    localparam int SC  = (SL_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int FSC = (FSL_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int QC  = (QT_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int AC  = (AL_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int WC  = (WK_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int FWC = (FWK_NS * 1000 + CLK_PS - 1) / CLK_PS;

    localparam logic [2:0] E_DATA = 3'd0, E_SLEEP = 3'd1, E_QUIET = 3'd2,
                           E_ALERT = 3'd3, E_WAKE = 3'd4, E_FW = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lpi_req = 1'b0;
    logic       fw_en = 1'b0;
    logic [2:0] tx_mode;
    logic       lpi_blk;
    logic       ram_start;
    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    lpi_tx_ctrl #(
        .CLK_PS(CLK_PS), .SLEEP_NS(SL_NS), .FW_SLEEP_NS(FSL_NS), .QUIET_NS(QT_NS),
        .ALERT_NS(AL_NS), .WAKE_NS(WK_NS), .FW_WAKE_NS(FWK_NS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lpi_req(lpi_req), .fw_en(fw_en),
        .tx_mode(tx_mode), .lpi_blk(lpi_blk), .ram_start(ram_start)
    );

    // One cycle: sample at the falling edge, compare mode, lpi_blk (R10) and ram_start (R9).
    task automatic chk(input logic [2:0] em, input logic first_wake, input string tag);
        logic eb;
        @(negedge clk);
        eb = (em == E_SLEEP) || (em == E_FW);
        n_chk++;
        if (tx_mode !== em || lpi_blk !== eb || ram_start !== first_wake) begin
            n_err++;
            $display("FAIL %s: mode=%0d blk=%0b ram=%0b expected mode=%0d blk=%0b ram=%0b",
                     tag, tx_mode, lpi_blk, ram_start, em, eb, first_wake);
        end
    endtask

    task automatic seg(input logic [2:0] em, input int n, input string tag);
        for (int i = 0; i < n; i++) chk(em, (em == E_WAKE) && (i == 0), tag);
    endtask

    initial begin
        int qpts[4];
        qpts = '{0, 1, QC/2, QC-1};
        // R1: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (tx_mode !== E_DATA || lpi_blk !== 1'b0 || ram_start !== 1'b0) begin
            n_err++;
            $display("FAIL R1 in reset: mode=%0d blk=%0b ram=%0b expected 0 0 0", tx_mode, lpi_blk, ram_start);
        end
        rst_n = 1'b1;
        seg(E_DATA, 3, "R1 idle");

        // R2, R4: drop in every cycle of SLEEP, expiry cycle included
        for (int j = 0; j < SC; j++) begin
            lpi_req = 1'b1;
            seg(E_SLEEP, j + 1, "R2 sleep");
            lpi_req = 1'b0;
            seg(E_WAKE, WC, "R4 wake");
            seg(E_DATA, 2, "R4 back to data");
        end

        // R3, R11: full refresh cycle with request held
        lpi_req = 1'b1;
        seg(E_SLEEP, SC, "R2 sleep length");
        seg(E_QUIET, QC, "R3 quiet");
        seg(E_ALERT, AC, "R3 alert");
        seg(E_WAKE, WC, "R3 refresh wake");
        seg(E_SLEEP, 3, "R11 re-sleep");
        lpi_req = 1'b0;
        seg(E_WAKE, WC, "R4 wake");
        seg(E_DATA, 2, "R4 data");

        // R5: drop at chosen points of QUIET, last cycle coincides with expiry
        for (int k = 0; k < 4; k++) begin
            lpi_req = 1'b1;
            seg(E_SLEEP, SC, "R2 sleep");
            seg(E_QUIET, qpts[k] + 1, "R5 quiet");
            lpi_req = 1'b0;
            seg(E_ALERT, AC, "R5 alert");
            seg(E_WAKE, WC, "R5 wake");
            seg(E_DATA, 2, "R5 data");
        end

        // R6: request toggled within ALERT
        lpi_req = 1'b1;
        seg(E_SLEEP, SC, "R2 sleep");
        seg(E_QUIET, QC, "R3 quiet");
        for (int i = 0; i < AC; i++) begin
            chk(E_ALERT, 1'b0, "R6 alert");
            lpi_req = (i == AC - 1);
        end
        seg(E_WAKE, WC, "R6 wake");
        seg(E_SLEEP, 2, "R6 sleep after");
        lpi_req = 1'b0;
        seg(E_WAKE, WC, "R4 wake");
        seg(E_DATA, 2, "R4 data");

        // R11: request raised in the final WAKE cycle with fast-wake on
        lpi_req = 1'b1;
        seg(E_SLEEP, 2, "R2 sleep");
        lpi_req = 1'b0;
        seg(E_WAKE, WC - 1, "R4 wake");
        chk(E_WAKE, 1'b0, "R11 wake end");
        lpi_req = 1'b1;
        fw_en = 1'b1;
        seg(E_FW, FSC, "R11 into fw");
        lpi_req = 1'b0;
        seg(E_WAKE, FWC, "R8 fast wake");
        seg(E_DATA, 2, "R8 data");

        // R7, R8: drop at every offset around the minimum FW dwell, plus a long hold
        for (int j = 0; j <= FSC + 2; j++) begin
            int hold;
            hold = (j == FSC + 2) ? 200 : j;
            lpi_req = 1'b1;
            for (int i = 0; i <= ((hold > FSC - 1) ? hold : FSC - 1); i++) begin
                chk(E_FW, 1'b0, "R7 fw hold");
                if (i == hold) lpi_req = 1'b0;
            end
            seg(E_WAKE, FWC, "R8 fast wake");
            seg(E_DATA, 2, "R8 data");
        end
        fw_en = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog: mode=%0d expected run to complete", tx_mode);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule